// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs a 12-bit successive-approximation converter that has a parallel data bus. When the user logic asks for a sample, the sequencer pulls the active-low conversion-start line low for a fixed number of clock cycles. It then waits for the converter's busy flag to rise and fall again. After busy has dropped, it lowers chip select and read together. It samples the 12-bit straight-binary word on the last cycle of that access and hands the word to the user logic with a single-cycle valid pulse.

The end of conversion is taken from the falling edge of busy, so the sequencer needs no fixed conversion delay. A converter's first result after power-up may be wrong. For that reason the sequencer runs one conversion by itself as soon as reset is released and throws the result away. Only after that does it report ready and accept user requests. A request that arrives while the sequencer is busy is remembered, and one such request is served afterwards. If busy fails to rise, or fails to fall, within a parameterised window, the sequencer returns to idle and raises an error pulse.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is asserted, convStN, csN and rdN are high, sampleValid, timeoutErr and ready are 0, and sampleData is 0.
- R2: After reset the block performs exactly one conversion and read without any user request, raises no sampleValid for it, and only then raises ready.
- R3: Every conversion start holds convStN low for exactly CONV_LOW_CYC clock cycles.
- R4: csN and rdN fall only after busy has been seen high following the conversion start and then seen low through the two-stage synchroniser. csN never falls while busy is high.
- R5: csN and rdN are always equal. Each read holds them low for exactly RD_CYC cycles, and never while convStN is low.
- R6: sampleData takes the value on dataBus in the last cycle of the read. sampleValid is high for exactly one cycle, in the cycle right after csN and rdN return high.
- R7: ready is 1 only when the sequencer is idle and the discarded first conversion is done. It is 0 from the cycle after an accepted request until the read or timeout finishes.
- R8: Any number of requests that arrive while the sequencer is not ready produce exactly one further conversion once the current one finishes.
- R9: If busy does not rise within TIMEOUT_CYC cycles after the start pulse ends, timeoutErr pulses for one cycle, no sampleValid is produced, and ready returns.
- R10: If busy rises but does not fall within TIMEOUT_CYC cycles, timeoutErr pulses for one cycle, no read is performed, and ready returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleReq | input | 1 | Request one conversion (level sampled each cycle) |
| busyIn | input | 1 | Converter busy flag, asynchronous |
| dataBus | input | 12 | Converter parallel data bus |
| convStN | output | 1 | Conversion start, active low |
| csN | output | 1 | Chip select, active low |
| rdN | output | 1 | Read strobe, active low |
| sampleData | output | 12 | Captured straight-binary result |
| sampleValid | output | 1 | One-cycle pulse marking a new sampleData |
| ready | output | 1 | Idle and accepting requests |
| timeoutErr | output | 1 | One-cycle pulse when busy does not rise or does not fall in time |

## Verification
Results with all bits zero, all bits one, alternating bits, only the MSB set and only the LSB set are passed through the behavioural converter. These codes show whether the capture point is in the right place and whether bits are swapped or stuck, because outside a read the model drives a different word onto the bus. A run of several requests during a single conversion shows whether the pending flag holds exactly one request or counts them. A converter that never raises busy and one whose busy stays high show the two timeout paths apart. A conversion that follows them shows that the sequencer recovers.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_READ
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;   // restart the phase counter
    logic convLow;  // drive conversion start active
    logic rdLow;    // drive chip select and read active
    logic publish;  // last read cycle of a user conversion
    logic fault;    // busy window expired
  } seqStrobe_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleReq,
  input  logic       busySync,
  input  logic       lowDone,
  input  logic       readDone,
  input  logic       waitExpired,
  output seqStrobe_t strb,
  output logic       ready
);

  seqState_t state, nextState;
  logic      dummyPend;
  logic      reqPend;
  logic      startUser;

  assign startUser = (state == ST_IDLE) && !dummyPend && (sampleReq || reqPend);
  assign ready     = (state == ST_IDLE) && !dummyPend;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (dummyPend || sampleReq || reqPend) begin
          nextState   = ST_START;
          strb.cntClr = 1'b1;
        end
      end
      ST_START: begin
        strb.convLow = 1'b1;
        if (lowDone) begin
          nextState   = ST_WAIT_HI;
          strb.cntClr = 1'b1;
        end
      end
      ST_WAIT_HI: begin
        if (busySync) begin
          nextState   = ST_WAIT_LO;
          strb.cntClr = 1'b1;
        end else if (waitExpired) begin
          nextState   = ST_IDLE;
          strb.cntClr = 1'b1;
          strb.fault  = 1'b1;
        end
      end
      ST_WAIT_LO: begin
        if (!busySync) begin
          nextState   = ST_READ;
          strb.cntClr = 1'b1;
        end else if (waitExpired) begin
          nextState   = ST_IDLE;
          strb.cntClr = 1'b1;
          strb.fault  = 1'b1;
        end
      end
      ST_READ: begin
        strb.rdLow = 1'b1;
        if (readDone) begin
          nextState    = ST_IDLE;
          strb.cntClr  = 1'b1;
          strb.publish = !dummyPend;
        end
      end
      default: begin
        nextState   = ST_IDLE;
        strb.cntClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dummyPend <= 1'b1;
      reqPend   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_READ && readDone)
        dummyPend <= 1'b0;
      if (startUser)
        reqPend <= 1'b0;
      else if (sampleReq)
        reqPend <= 1'b1;
    end
  end

  // The read opens only on a cycle where the synchronised busy was low
  assert_read_after_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && $past(state) == ST_WAIT_LO) |-> !$past(busySync));

  // The discarded conversion ends with a completed read
  assert_dummy_ends_on_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dummyPend) |-> $past(state) == ST_READ);

  // A held request is served as soon as the sequencer is idle
  assert_pending_served_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqPend && state == ST_IDLE && !dummyPend) |=> (state == ST_START && !reqPend));

  // Ready never coexists with a start pulse or read
  assert_ready_only_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !strb.convLow && !strb.rdLow);

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int CONV_LOW_CYC = 4,
  parameter int RD_CYC       = 4,
  parameter int TIMEOUT_CYC  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] dataBus,
  output logic              busySync,
  output logic              lowDone,
  output logic              readDone,
  output logic              waitExpired,
  output logic              convStN,
  output logic              csN,
  output logic              rdN,
  output logic [DATA_W-1:0] sampleData,
  output logic              sampleValid,
  output logic              timeoutErr
);

  localparam int LIM_MAX = maxOf3(CONV_LOW_CYC, RD_CYC, TIMEOUT_CYC);
  localparam int CNT_W   = $clog2(LIM_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(LIM_MAX);
  localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(CONV_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CYC - 1);

  logic             busyMeta;
  logic [CNT_W-1:0] cnt;

  // Two-stage synchroniser for the asynchronous busy flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyMeta <= 1'b0;
      busySync <= 1'b0;
    end else begin
      busyMeta <= busyIn;
      busySync <= busyMeta;
    end
  end

  // Shared phase counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (strb.cntClr)
      cnt <= '0;
    else if (cnt != CNT_TOP)
      cnt <= cnt + 1'b1;
  end

  assign lowDone     = (cnt == LOW_LAST);
  assign readDone    = (cnt == RD_LAST);
  assign waitExpired = (cnt == TO_LAST);

  assign convStN = ~strb.convLow;
  assign csN     = ~strb.rdLow;
  assign rdN     = ~strb.rdLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleData  <= '0;
      sampleValid <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      sampleValid <= strb.publish;
      timeoutErr  <= strb.fault;
      if (strb.publish)
        sampleData <= dataBus;
    end
  end

  assert_start_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStN) |-> $past(cnt) == LOW_LAST);

  assert_read_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> $past(cnt) == RD_LAST);

  assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (rdN && $past(!rdN)));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr);

  assert_err_no_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !sampleValid);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int CONV_LOW_CYC = 4,
  parameter int RD_CYC       = 4,
  parameter int TIMEOUT_CYC  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleReq,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] dataBus,
  output logic              convStN,
  output logic              csN,
  output logic              rdN,
  output logic [DATA_W-1:0] sampleData,
  output logic              sampleValid,
  output logic              ready,
  output logic              timeoutErr
);

  seqStrobe_t strb;
  logic       busySync;
  logic       lowDone;
  logic       readDone;
  logic       waitExpired;

  adc_seq_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleReq   (sampleReq),
    .busySync    (busySync),
    .lowDone     (lowDone),
    .readDone    (readDone),
    .waitExpired (waitExpired),
    .strb        (strb),
    .ready       (ready)
  );

  adc_seq_dp #(
    .DATA_W       (DATA_W),
    .CONV_LOW_CYC (CONV_LOW_CYC),
    .RD_CYC       (RD_CYC),
    .TIMEOUT_CYC  (TIMEOUT_CYC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busyIn      (busyIn),
    .dataBus     (dataBus),
    .busySync    (busySync),
    .lowDone     (lowDone),
    .readDone    (readDone),
    .waitExpired (waitExpired),
    .convStN     (convStN),
    .csN         (csN),
    .rdN         (rdN),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .timeoutErr  (timeoutErr)
  );

endmodule

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;

  localparam int DW      = 12;
  localparam int LOW_CYC = 3;
  localparam int RD_CYC  = 4;
  localparam int TO_CYC  = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleReq = 1'b0;
  logic          busyIn = 1'b0;
  logic [DW-1:0] dataBus;
  logic          convStN, csN, rdN, sampleValid, ready, timeoutErr;
  logic [DW-1:0] sampleData;

  int nChecks = 0;
  int nFail   = 0;
  int convCount = 0;
  int validCount = 0;
  int errCount = 0;
  int modelMode = 0;       // 0 normal, 1 busy never rises, 2 busy stuck high
  logic [DW-1:0] heldCode = 12'h000;
  logic [DW-1:0] codeQ[$];
  logic [DW-1:0] expQ[$];
  bit   finished = 0;

  always #2.5 clk = ~clk;

  adc_seq_top #(
    .DATA_W       (DW),
    .CONV_LOW_CYC (LOW_CYC),
    .RD_CYC       (RD_CYC),
    .TIMEOUT_CYC  (TO_CYC)
  ) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleReq   (sampleReq),
    .busyIn      (busyIn),
    .dataBus     (dataBus),
    .convStN     (convStN),
    .csN         (csN),
    .rdN         (rdN),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .ready       (ready),
    .timeoutErr  (timeoutErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural converter
  assign dataBus = (!csN && !rdN) ? heldCode : 12'hBAD;

  initial begin
    forever begin
      @(negedge convStN);
      convCount++;
      if (modelMode != 1) begin
        repeat (2) @(posedge clk);
        busyIn <= 1'b1;
        if (modelMode == 0) begin
          repeat (25) @(posedge clk);
          heldCode <= (codeQ.size() > 0) ? codeQ.pop_front() : 12'hFFF;
          busyIn   <= 1'b0;
        end
      end
    end
  end

  // Monitors
  int  lowRun = 0, rdRun = 0, busyLowRun = 0;
  bit  busySeen = 0, pairOk = 1, overlapOk = 1;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (!convStN) begin
        lowRun++;
        busySeen = busySeen || busyIn;
      end else if (lowRun > 0) begin
        check(lowRun == LOW_CYC, "R3 start width", lowRun, LOW_CYC);
        lowRun = 0;
      end
      if (convStN === 1'b1 && lowRun == 0 && busyIn) busySeen = 1;
      if (csN != rdN) pairOk = 0;
      if (!csN && !convStN) overlapOk = 0;
      if (!csN) begin
        if (rdRun == 0)
          check(busySeen && !busyIn && busyLowRun >= 2, "R4 read after busy fall",
                busyLowRun, 2);
        rdRun++;
      end else if (rdRun > 0) begin
        check(rdRun == RD_CYC && pairOk && overlapOk, "R5 read width/pairing",
              rdRun, RD_CYC);
        rdRun = 0; pairOk = 1; overlapOk = 1; busySeen = 0;
      end
      busyLowRun = busyIn ? 0 : busyLowRun + 1;
      if (ready && (!convStN || !csN))
        check(0, "R7 ready while active", 1, 0);
      if (sampleValid) begin
        validCount++;
        if (expQ.size() == 0)
          check(0, "R2/R8 unexpected sampleValid", sampleData, 0);
        else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          check(sampleData == e, "R6 captured data", sampleData, e);
        end
      end
      if (timeoutErr) errCount++;
    end
  end

  task automatic waitReady(input string req);
    int n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
    check(ready, req, ready, 1);
  endtask

  task automatic pulseReq();
    @(negedge clk) sampleReq = 1'b1;
    @(negedge clk) sampleReq = 1'b0;
  endtask

  task automatic doSample(input logic [DW-1:0] code);
    int v0;
    v0 = validCount;
    codeQ.push_back(code);
    expQ.push_back(code);
    pulseReq();
    check(!ready, "R7 ready low after request", ready, 0);
    waitReady("R7 ready returns");
    @(negedge clk);
    check(validCount == v0 + 1, "R6 one valid per request", validCount, v0 + 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int c0, v0, e0;
    repeat (4) @(negedge clk);
    // R1 reset values
    check(convStN && csN && rdN, "R1 strobes high in reset", {convStN, csN, rdN}, 3'b111);
    check(!sampleValid && !timeoutErr && !ready, "R1 flags low in reset",
          {sampleValid, timeoutErr, ready}, 0);
    check(sampleData == 0, "R1 data cleared", sampleData, 0);
    rstN = 1'b1;
    // R2 discarded first conversion
    waitReady("R2 ready after dummy");
    check(convCount == 1 && validCount == 0, "R2 one silent dummy", convCount * 16 + validCount, 16);

    // Main function, several code patterns
    doSample(12'h000);
    doSample(12'hFFF);
    doSample(12'h5A5);
    doSample(12'h800);
    doSample(12'h001);

    // R8: burst of requests during a conversion
    c0 = convCount; v0 = validCount;
    codeQ.push_back(12'h3C3); expQ.push_back(12'h3C3);
    codeQ.push_back(12'hC3C); expQ.push_back(12'hC3C);
    pulseReq();
    repeat (8) @(negedge clk);
    repeat (3) begin pulseReq(); repeat (4) @(negedge clk); end
    repeat (200) @(negedge clk);
    check(convCount == c0 + 2, "R8 one extra conversion", convCount - c0, 2);
    check(validCount == v0 + 2 && expQ.size() == 0, "R8 two results", validCount - v0, 2);
    check(ready, "R8 idle afterwards", ready, 1);

    // R9: busy never rises
    modelMode = 1; e0 = errCount; v0 = validCount;
    pulseReq();
    repeat (LOW_CYC + TO_CYC + 20) @(negedge clk);
    check(errCount == e0 + 1, "R9 timeout pulse", errCount - e0, 1);
    check(validCount == v0, "R9 no data", validCount - v0, 0);
    check(ready, "R9 ready returns", ready, 1);

    // R10: busy stuck high
    modelMode = 2; e0 = errCount; v0 = validCount;
    pulseReq();
    repeat (LOW_CYC + TO_CYC + 20) @(negedge clk);
    check(errCount == e0 + 1, "R10 timeout pulse", errCount - e0, 1);
    check(validCount == v0 && rdRun == 0, "R10 no read", validCount - v0, 0);
    check(ready, "R10 ready returns", ready, 1);
    busyIn = 1'b0; modelMode = 0;
    repeat (5) @(negedge clk);

    // Recovery
    doSample(12'hA5A);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule